// File: doc/BRIEF.md
# Byte-Packing DMA Channel for a Byte-Wide Peripheral

This block moves data between a peripheral that produces or consumes one byte at a time and a memory that is 32 bits wide, in either direction. Towards memory, incoming bytes are gathered most-significant lane first into a pack word. Each time the fourth byte arrives, the block issues one full-word write. Towards the peripheral, the block fetches a word, keeps it as a single cached entry, and hands out its bytes one by one. The low two bits of a running byte address select each byte.

Movement happens only while the channel is enabled and the peripheral holds its request line high. When the request drops, the channel pauses and keeps all of its state: the partial pack word, the two-bit pack count, the cached word, the address and the byte counter. A later burst therefore continues in the middle of a word. The pack count is presented as an output so that surrounding control logic can hold it in a status field. A synchronous flush discards the partial state. A one-cycle pulse reports that the byte counter has run down to zero.

Top module: `dmapk_channel`

## Requirements
- R1: A byte moves (per_ack in the to-memory direction, per_wr_stb in the to-peripheral direction) only in a cycle where dma_en and per_req are both 1 and flush is 0. Otherwise address, count, pack count and partial data hold their values.
- R2: In the to-memory direction (dir_to_mem = 1), a byte accepted while pack_cnt = k goes into bits [8*(3-k)+7 : 8*(3-k)] of the pack word, so the first byte of a word lands in bits 31:24.
- R3: The byte that finds pack_cnt = 3 completes the word. One write is issued carrying the completed word, mem_req_be = 4'b1111, and the word address cur_addr[AW-1:2]. pack_cnt returns to 0 and the next word starts from zero. cur_addr is never advanced in the to-memory direction.
- R4: pack_cnt (0 to 3) counts bytes held in the partial word and keeps its value while transfer is paused.
- R5: cur_count decrements by one for each byte moved, only when cnt_en is 1. A load via ld_cnt takes priority over the decrement.
- R6: In the to-peripheral direction (dir_to_mem = 0), a read request is issued only when no word is cached. The byte presented is bits [8*(3-a)+7 : 8*(3-a)] of the cached word, where a = cur_addr[1:0].
- R7: In the to-peripheral direction, cur_addr increments by one per byte sent. The cached word is dropped after the byte with cur_addr[1:0] = 3, so the next byte causes a new fetch.
- R8: The memory port keeps at most one request outstanding. mem_req_valid stays high with stable fields until mem_req_ready. While a memory transaction is in progress, no byte is accepted from the peripheral.
- R9: flush clears pack_cnt, the partial word and the cached word in one cycle, and no byte moves in a cycle where flush is 1.
- R10: xfer_done is high for exactly the one cycle after a byte moved with cnt_en = 1 while cur_count was 1.
- R11: After reset, pack_cnt, cur_addr and cur_count are 0, and per_ack, per_wr_stb, mem_req_valid and xfer_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Channel enable |
| dir_to_mem | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| cnt_en | input | 1 | Enable byte counter decrement |
| flush | input | 1 | Discard partial word, pack count and cached word |
| ld_addr | input | 1 | Load cur_addr from addr_in |
| addr_in | input | AW | Byte address to load |
| ld_cnt | input | 1 | Load cur_count from cnt_in |
| cnt_in | input | CW | Byte count to load |
| per_req | input | 1 | Peripheral request pending |
| per_rd_data | input | 8 | Byte offered by the peripheral |
| per_ack | output | 1 | Byte on per_rd_data taken this cycle |
| per_wr_data | output | 8 | Byte offered to the peripheral |
| per_wr_stb | output | 1 | per_wr_data is valid this cycle |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | AW-2 | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Byte lane enables |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| cur_addr | output | AW | Running byte address |
| cur_count | output | CW | Remaining byte count |
| pack_cnt | output | 2 | Bytes held in the partial word |
| xfer_done | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The flush input and a byte transfer can be asked for in the same cycle. The most pointed case is a flush while the request is high and the pack word is partly full, or while a cached word is mid-way through. The bench raises flush at random during active bursts in both directions, and once on purpose with two bytes packed. Its reference model expects no byte to move in that cycle and pack_cnt to read 0 in the next one. A second overlap, a count load coinciding with a byte move, is also driven, and the reference expects the loaded value to win.

// File: rtl/dmapk_pkg.sv
package dmapk_pkg;

    localparam int LANE_W   = 8;
    localparam int LANES    = 4;
    localparam int WORD_W   = LANE_W * LANES;
    localparam int SLOT_W   = $clog2(LANES);

    typedef logic [LANE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [1:0] {
        MP_IDLE   = 2'd0,
        MP_WR     = 2'd1,
        MP_RDREQ  = 2'd2,
        MP_RDWAIT = 2'd3
    } mp_state_e;

    typedef struct packed {
        logic  we;
        word_t data;
    } mem_cmd_t;

    // Lane k of the word counted from the most significant end
    function automatic word_t lane_insert(word_t w, byte_t b, slot_t slot);
        slot_t rev;
        rev = slot_t'(LANES - 1) - slot;
        return w | (word_t'(b) << (int'(rev) * LANE_W));
    endfunction

    function automatic byte_t lane_pick(word_t w, slot_t slot);
        slot_t rev;
        rev = slot_t'(LANES - 1) - slot;
        return byte_t'(w >> (int'(rev) * LANE_W));
    endfunction

endpackage

// File: rtl/dmapk_pack.sv
module dmapk_pack import dmapk_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  take,
    input  byte_t byte_in,
    output slot_t pack_cnt,
    output logic  word_full,
    output word_t full_word
);
    word_t acc_q;
    slot_t cnt_q;
    word_t acc_next;

    always_comb begin
        acc_next  = lane_insert(acc_q, byte_in, cnt_q);
        word_full = take && (cnt_q == slot_t'(LANES - 1));
        full_word = acc_next;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            if (word_full) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= acc_next;
                cnt_q <= cnt_q + slot_t'(1);
            end
        end
    end

    assign pack_cnt = cnt_q;

    AST_PACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!take && !flush) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/dmapk_unpack.sv
module dmapk_unpack import dmapk_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  fill,
    input  word_t fill_word,
    input  logic  give,
    input  slot_t addr_lo,
    output logic  cached,
    output byte_t byte_out
);
    word_t line_q;
    logic  valid_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= 1'b0;
            line_q  <= '0;
        end else if (fill) begin
            valid_q <= 1'b1;
            line_q  <= fill_word;
        end else if (give && addr_lo == slot_t'(LANES - 1)) begin
            valid_q <= 1'b0;
        end
    end

    assign cached   = valid_q;
    assign byte_out = lane_pick(line_q, addr_lo);

    AST_NO_FILL_WHEN_CACHED: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> !fill); // R6
endmodule

// File: rtl/dmapk_memport.sv
module dmapk_memport import dmapk_pkg::*; #(
    parameter int WAW = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_start,
    input  logic           rd_start,
    input  logic [WAW-1:0] start_waddr,
    input  word_t          wr_word,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic           mem_req_we,
    output logic [WAW-1:0] mem_req_addr,
    output word_t          mem_req_wdata,
    output logic [LANES-1:0] mem_req_be,
    input  logic           mem_rsp_valid,
    input  word_t          mem_rsp_rdata,
    output logic           busy,
    output logic           fill,
    output word_t          fill_word
);
    mp_state_e      st_q;
    mem_cmd_t       cmd_q;
    logic [WAW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= MP_IDLE;
            cmd_q  <= '0;
            addr_q <= '0;
        end else begin
            case (st_q)
                MP_IDLE: begin
                    if (wr_start) begin
                        st_q   <= MP_WR;
                        cmd_q  <= '{we: 1'b1, data: wr_word};
                        addr_q <= start_waddr;
                    end else if (rd_start) begin
                        st_q   <= MP_RDREQ;
                        cmd_q  <= '{we: 1'b0, data: '0};
                        addr_q <= start_waddr;
                    end
                end
                MP_WR:     if (mem_req_ready) st_q <= MP_IDLE;
                MP_RDREQ:  if (mem_req_ready) st_q <= MP_RDWAIT;
                MP_RDWAIT: if (mem_rsp_valid) st_q <= MP_IDLE;
                default:   st_q <= MP_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_valid = (st_q == MP_WR) || (st_q == MP_RDREQ);
        mem_req_we    = cmd_q.we;
        mem_req_addr  = addr_q;
        mem_req_wdata = cmd_q.data;
        mem_req_be    = mem_req_valid ? {LANES{1'b1}} : '0;
        busy          = (st_q != MP_IDLE);
        fill          = (st_q == MP_RDWAIT) && mem_rsp_valid;
        fill_word     = mem_rsp_rdata;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata))); // R8
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (st_q == MP_RDWAIT) |-> !mem_req_valid); // R8
endmodule

// File: rtl/dmapk_channel.sv
module dmapk_channel import dmapk_pkg::*; #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dma_en,
    input  logic          dir_to_mem,
    input  logic          cnt_en,
    input  logic          flush,
    input  logic          ld_addr,
    input  logic [AW-1:0] addr_in,
    input  logic          ld_cnt,
    input  logic [CW-1:0] cnt_in,
    input  logic          per_req,
    input  logic [7:0]    per_rd_data,
    output logic          per_ack,
    output logic [7:0]    per_wr_data,
    output logic          per_wr_stb,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-3:0] mem_req_addr,
    output logic [31:0]   mem_req_wdata,
    output logic [3:0]    mem_req_be,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_rdata,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_count,
    output logic [1:0]    pack_cnt,
    output logic          xfer_done
);
    localparam int WAW = AW - SLOT_W;

    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    logic  run;
    logic  take_w, give_r, fetch;
    logic  moved;
    logic  busy, fill, cached, word_full;
    word_t fill_word, full_word;
    slot_t pcnt;
    byte_t out_byte;

    always_comb begin
        run    = dma_en && per_req && !flush;
        take_w = run && dir_to_mem && !busy;
        give_r = run && !dir_to_mem && cached;
        fetch  = run && !dir_to_mem && !cached && !busy;
        moved  = take_w || give_r;
    end

    dmapk_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .take      (take_w),
        .byte_in   (per_rd_data),
        .pack_cnt  (pcnt),
        .word_full (word_full),
        .full_word (full_word)
    );

    dmapk_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .fill      (fill),
        .fill_word (fill_word),
        .give      (give_r),
        .addr_lo   (addr_q[SLOT_W-1:0]),
        .cached    (cached),
        .byte_out  (out_byte)
    );

    dmapk_memport #(.WAW(WAW)) u_mem (
        .clk           (clk),
        .rst           (rst),
        .wr_start      (word_full),
        .rd_start      (fetch),
        .start_waddr   (addr_q[AW-1:SLOT_W]),
        .wr_word       (full_word),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_req_be    (mem_req_be),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .busy          (busy),
        .fill          (fill),
        .fill_word     (fill_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (ld_addr)     addr_q <= addr_in;
            else if (give_r) addr_q <= addr_q + AW'(1);

            if (ld_cnt)               cnt_q <= cnt_in;
            else if (moved && cnt_en) cnt_q <= cnt_q - CW'(1);

            done_q <= !ld_cnt && moved && cnt_en && (cnt_q == CW'(1));
        end
    end

    assign per_ack     = take_w;
    assign per_wr_stb  = give_r;
    assign per_wr_data = out_byte;
    assign cur_addr    = addr_q;
    assign cur_count   = cnt_q;
    assign pack_cnt    = pcnt;
    assign xfer_done   = done_q;

    AST_NO_MOVE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(dma_en && per_req) |-> (!per_ack && !per_wr_stb)); // R1
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (pack_cnt == 2'd0)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done); // R10
    AST_WADDR_FIXED: assert property (@(posedge clk) disable iff (rst)
        (dir_to_mem && !ld_addr) |=> $stable(cur_addr)); // R3
    AST_STALL_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !per_ack); // R8
endmodule

// File: tb/dmapk_channel_test.sv
`timescale 1ns/1ps
module dmapk_channel_test;
    localparam int AW = 16;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dma_en = 0, dir_to_mem = 0, cnt_en = 0, flush = 0;
    logic ld_addr = 0, ld_cnt = 0;
    logic [AW-1:0] addr_in = '0;
    logic [CW-1:0] cnt_in = '0;
    logic per_req = 0;
    logic [7:0] per_rd_data = '0;
    logic per_ack, per_wr_stb;
    logic [7:0] per_wr_data;
    logic mem_req_valid, mem_req_we;
    logic mem_req_ready = 0;
    logic [AW-3:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic [3:0] mem_req_be;
    logic mem_rsp_valid = 0;
    logic [31:0] mem_rsp_rdata = '0;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_count;
    logic [1:0] pack_cnt;
    logic xfer_done;

    int vectors = 0;
    int miscompares = 0;

    dmapk_channel #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .dma_en(dma_en), .dir_to_mem(dir_to_mem),
        .cnt_en(cnt_en), .flush(flush), .ld_addr(ld_addr), .addr_in(addr_in),
        .ld_cnt(ld_cnt), .cnt_in(cnt_in), .per_req(per_req),
        .per_rd_data(per_rd_data), .per_ack(per_ack), .per_wr_data(per_wr_data),
        .per_wr_stb(per_wr_stb), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_be(mem_req_be), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .cur_addr(cur_addr),
        .cur_count(cur_count), .pack_cnt(pack_cnt), .xfer_done(xfer_done)
    );

    always #10 clk = ~clk;

    // Behavioural reference: 0 idle, 1 write pending, 2 read request, 3 read wait
    int m_mst = 0;
    int m_pc = 0;
    longint m_pack = 0;
    bit m_cached = 0;
    longint m_word = 0;
    int m_addr = 0;
    int m_cnt = 0;
    bit m_done = 0;
    int m_waddr = 0;
    longint m_wdata = 0;
    int m_raddr = 0;
    int src_idx = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit rnd_flush = 0;

    function automatic int src_byte(int i);
        return (i * 37 + 5) & 255;
    endfunction

    function automatic longint mem_word(int wa);
        int b;
        b = wa & 255;
        return (longint'(b ^ 8'h3C) << 24) | (longint'((b + 8'h11) & 255) << 16)
             | (longint'((~b) & 255) << 8) | longint'(b ^ 8'hC3);
    endfunction

    always @(posedge clk) begin
        bit run, go_w, go_r, fetch;
        if (rst) begin
            m_mst = 0; m_pc = 0; m_pack = 0; m_cached = 0; m_word = 0;
            m_addr = 0; m_cnt = 0; m_done = 0; m_waddr = 0; m_wdata = 0; m_raddr = 0;
        end else begin
            run   = dma_en && per_req && !flush;
            go_w  = run && dir_to_mem && m_mst == 0;
            go_r  = run && !dir_to_mem && m_cached;
            fetch = run && !dir_to_mem && !m_cached && m_mst == 0;
            m_done = !ld_cnt && (go_w || go_r) && cnt_en && m_cnt == 1;
            case (m_mst)
                0: if (go_w && m_pc == 3) begin
                       m_mst = 1; m_waddr = m_addr >> 2;
                       m_wdata = m_pack | longint'(per_rd_data);
                   end else if (fetch) begin
                       m_mst = 2; m_raddr = m_addr >> 2;
                   end
                1: if (mem_req_ready) m_mst = 0;
                2: if (mem_req_ready) m_mst = 3;
                default: if (mem_rsp_valid) begin
                       m_mst = 0; m_cached = 1; m_word = longint'(mem_rsp_rdata);
                   end
            endcase
            if (go_w) begin
                src_idx++;
                if (m_pc == 3) begin m_pack = 0; m_pc = 0; end
                else begin
                    m_pack = m_pack | (longint'(per_rd_data) << (8 * (3 - m_pc)));
                    m_pc++;
                end
            end
            if (go_r && (m_addr & 3) == 3) m_cached = 0;
            if (flush) begin m_pack = 0; m_pc = 0; m_cached = 0; end
            if (ld_cnt) m_cnt = int'(cnt_in);
            else if ((go_w || go_r) && cnt_en) m_cnt = (m_cnt - 1) & 16'hFFFF;
            if (ld_addr) m_addr = int'(addr_in);
            else if (go_r) m_addr = (m_addr + 1) & 16'hFFFF;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit run, e_ack, e_stb, e_v;
        int e_wd, e_addr;
        run   = dma_en && per_req && !flush;
        e_ack = run && dir_to_mem && m_mst == 0;
        e_stb = run && !dir_to_mem && m_cached;
        e_wd  = int'((m_word >> (8 * (3 - (m_addr & 3)))) & 255);
        e_v   = (m_mst == 1) || (m_mst == 2);
        e_addr = (m_mst == 1) ? m_waddr : m_raddr;
        chk(per_ack == e_ack, "R1 per_ack", per_ack, e_ack);
        chk(per_wr_stb == e_stb, "R1 per_wr_stb", per_wr_stb, e_stb);
        if (e_stb) chk(int'(per_wr_data) == e_wd, "R6 per_wr_data", per_wr_data, e_wd);
        chk(mem_req_valid == e_v, "R8 mem_req_valid", mem_req_valid, e_v);
        if (e_v) begin
            chk(mem_req_we == (m_mst == 1), "R8 mem_req_we", mem_req_we, m_mst == 1);
            chk(int'(mem_req_addr) == e_addr, "R3 mem_req_addr", mem_req_addr, e_addr);
            if (m_mst == 1) begin
                chk(longint'(mem_req_wdata) == m_wdata, "R2 mem_req_wdata", mem_req_wdata, m_wdata);
                chk(mem_req_be == 4'hF, "R3 mem_req_be", mem_req_be, 4'hF);
            end
        end
        chk(int'(pack_cnt) == m_pc, "R4 pack_cnt", pack_cnt, m_pc);
        chk(int'(cur_addr) == m_addr, "R7 cur_addr", cur_addr, m_addr);
        chk(int'(cur_count) == m_cnt, "R5 cur_count", cur_count, m_cnt);
        chk(xfer_done == m_done, "R10 xfer_done", xfer_done, m_done);
    endtask

    // One cycle: drive at the falling edge, compare shortly after
    task automatic step(input bit req_on, input bit fl, input bit la, input int a,
                        input bit lc, input int c);
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        per_req       = req_on && (lfsr[1:0] != 2'b00);
        mem_req_ready = lfsr[3] | lfsr[5];
        mem_rsp_valid = (m_mst == 3) && (lfsr[7] | lfsr[2]);
        mem_rsp_rdata = 32'(mem_word(m_raddr));
        per_rd_data   = 8'(src_byte(src_idx));
        flush = (fl || (rnd_flush && lfsr[11:8] == 4'hF)) && m_mst != 2 && m_mst != 3;
        ld_addr = la; addr_in = AW'(a);
        ld_cnt = lc;  cnt_in = CW'(c);
        #2;
        compare();
    endtask

    task automatic run_n(input int n, input bit req_on);
        for (int i = 0; i < n; i++) step(req_on, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R11: reset state
        chk(pack_cnt == 2'd0 && cur_addr == '0 && cur_count == '0, "R11 reset regs",
            {pack_cnt, cur_addr, cur_count}, 0);
        chk(!per_ack && !per_wr_stb && !mem_req_valid && !xfer_done, "R11 reset outs",
            {per_ack, per_wr_stb, mem_req_valid, xfer_done}, 0);
        @(negedge clk); rst = 1'b0;

        // Peripheral to memory with counting; R2 R3 R4 R10
        dma_en = 1; dir_to_mem = 1; cnt_en = 1;
        step(0, 0, 1, 16'h0100, 1, 10);
        run_n(120, 1);
        // Pause keeps partial state (R4)
        run_n(10, 0);
        // Deliberate flush with two bytes packed and request high (R9)
        for (int i = 0; i < 200 && m_pc != 2; i++) step(1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        chk(pack_cnt == 2'd0, "R9 pack_cnt after flush", pack_cnt, 0);
        // Count disabled (R5) and random flushes
        cnt_en = 0; rnd_flush = 1;
        run_n(80, 1);
        // Load coinciding with transfer (R5)
        cnt_en = 1;
        step(1, 0, 0, 0, 1, 7);
        run_n(60, 1);

        // Memory to peripheral, unaligned start (R6 R7)
        dir_to_mem = 0;
        step(0, 0, 1, 16'h0202, 1, 25);
        rnd_flush = 0;
        run_n(150, 1);
        rnd_flush = 1;
        run_n(150, 1);
        // Disabled channel with request high (R1)
        dma_en = 0;
        run_n(20, 1);
        dma_en = 1; dir_to_mem = 1;
        run_n(60, 1);
        run_n(10, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule